// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one byte per request into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one, one-and-a-half or two bit times. The timing comes from an external strobe that pulses sixteen times per bit. The block has no divider of its own, so each bit lasts exactly sixteen strobes.

The frame shape is set by a set of line-control inputs: word length, stop select, parity enable, even/odd select, stick parity and break. All of them except break are captured when a byte is accepted. The frame in progress is therefore immune to later changes. Break works differently. It is applied live at the output, where it pulls the line low, and the framing logic behind it keeps counting as usual. A producer offers bytes with a valid/ready handshake, and ready is high only while the transmitter is idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, `tx_ready` is 1 and `tx_busy` is 0, and the line stays high whenever the block is idle.
- R2: An accepted byte produces a low start bit followed by data bits sent LSB first. Word-length code 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Every start, data and parity bit lasts 16 strobes.
- R3: With parity enable at 0, no parity bit is sent and the even/odd select has no effect: the stop period follows the last data bit directly.
- R4: With parity enable at 1, even select at 1 and stick at 0, the parity bit makes the number of ones in the data bits plus parity even.
- R5: With parity enable at 1, even select at 0 and stick at 0, the parity bit makes that number of ones odd.
- R6: With parity enable and stick both at 1, the parity bit is the constant 0 when even select is 1 and the constant 1 when even select is 0.
- R7: With stop select at 0 the high stop period lasts 16 strobes. With stop select at 1 it lasts 24 strobes for 5-bit words and 32 strobes for 6-, 7- and 8-bit words.
- R8: While break is 1 the output line is 0, whether the block is idle or busy. The frame timing, `tx_busy` and `tx_ready` do not change because of it.
- R9: Word length, stop select and the parity controls are captured in the cycle a byte is accepted. Changing them during a frame has no effect on that frame.
- R10: A byte is accepted on a clock edge where both valid and ready are 1. `tx_ready` is 1 only when idle, and `tx_busy` is 1 from the edge after acceptance until the edge of the last stop strobe. The line changes only on edges where the strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | Strobe, 16 pulses per bit time |
| tx_data | input | 8 | Byte to send; unused upper bits are ignored for short words |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| lc_wlen | input | 2 | Word length code (00=5 … 11=8 bits) |
| lc_stop | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| lc_par_en | input | 1 | Parity bit enable |
| lc_even | input | 1 | Even parity select |
| lc_stick | input | 1 | Stick parity enable |
| lc_break | input | 1 | Force the line low |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | A frame is in progress |

## Verification
If the bit counter, the captured line-control copy or the parity latch holds a wrong value, the line shows the wrong level within the same strobe window. It may come too early, sit at the wrong polarity, or run one parity slot or half a stop bit too long or too short. The bench predicts the expected line, ready and busy values for every clock cycle and compares them, so a fault is reported at the first cycle where the line diverges. A mistake in idle or break handling shows on the line or on ready in the first cycle it occurs.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int MAXW = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } tx_state_e;

  // number of data bits for a word-length code
  function automatic logic [3:0] word_bits(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

  // parity bit for the captured byte under the given controls
  function automatic logic frame_parity(input logic [MAXW-1:0] d,
                                        input logic [1:0] wl,
                                        input logic even,
                                        input logic stick);
    logic [MAXW-1:0] mask;
    logic            ones_odd;
    mask     = {MAXW{1'b1}} >> (2'd3 - wl);
    ones_odd = ^(d & mask);
    if (stick) return ~even;
    return even ? ones_odd : ~ones_odd;
  endfunction

  // length of the stop period in strobes
  function automatic int unsigned stop_ticks(input logic two,
                                             input logic [1:0] wl,
                                             input int unsigned ovs);
    if (!two) return ovs;
    if (wl == 2'b00) return ovs + ovs / 2;
    return 2 * ovs;
  endfunction

endpackage

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  assign done  = run && tick && (cnt_q == limit - 1'b1);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || done) cnt_q <= '0;
    else if (tick)         cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         lsb
);

  logic [W-1:0] sreg;

  assign lsb = sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= din;
    else if (shift) sreg <= sreg >> 1;
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [1:0] lc_wlen,
  input  logic       lc_stop,
  input  logic       lc_par_en,
  input  logic       lc_even,
  input  logic       lc_stick,
  input  logic       lc_break,
  output logic       tx_line,
  output logic       tx_busy
);
  import uft_pkg::*;

  localparam int CW = $clog2(2 * OVS + 1);
  localparam int IW = $clog2(MAXW);

  tx_state_e     state_q, state_d;
  logic [1:0]    wl_q;
  logic          two_q, pe_q, par_q;
  logic [IW-1:0] idx_q;

  // named internal events
  logic          accept;
  logic          run;
  logic          bit_done;
  logic          last_data;
  logic          data_shift;
  logic          data_lsb;
  logic          line_raw;
  logic [CW-1:0] bit_limit;
  logic [CW-1:0] stop_lim;
  logic [CW-1:0] bit_count;

  assign tx_ready   = (state_q == S_IDLE);
  assign accept     = tx_valid && tx_ready;
  assign run        = (state_q != S_IDLE);
  assign tx_busy    = run;
  assign stop_lim   = CW'(stop_ticks(two_q, wl_q, OVS));
  assign bit_limit  = (state_q == S_STOP) ? stop_lim : CW'(OVS);
  assign last_data  = ({1'b0, idx_q} == word_bits(wl_q) - 4'd1);
  assign data_shift = bit_done && (state_q == S_DATA);

  uft_bit_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick_16x),
    .limit (bit_limit),
    .count (bit_count),
    .done  (bit_done)
  );

  uft_shifter #(.W(MAXW)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (tx_data),
    .shift (data_shift),
    .lsb   (data_lsb)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (accept) state_d = S_START;
      S_START: if (bit_done) state_d = S_DATA;
      S_DATA:  if (bit_done && last_data) state_d = pe_q ? S_PAR : S_STOP;
      S_PAR:   if (bit_done) state_d = S_STOP;
      S_STOP:  if (bit_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wl_q    <= 2'b00;
      two_q   <= 1'b0;
      pe_q    <= 1'b0;
      par_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wl_q  <= lc_wlen;
        two_q <= lc_stop;
        pe_q  <= lc_par_en;
        par_q <= frame_parity(tx_data, lc_wlen, lc_even, lc_stick);
        idx_q <= '0;
      end else if (data_shift) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (state_q)
      S_START: line_raw = 1'b0;
      S_DATA:  line_raw = data_lsb;
      S_PAR:   line_raw = par_q;
      default: line_raw = 1'b1;
    endcase
  end

  // break acts only at the pin
  assign tx_line = line_raw & ~lc_break;

endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic accept,
  input logic busy,
  input logic ready,
  input logic brk,
  input logic line_out,
  input logic line_raw
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_raw);

  assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !line_raw));

  assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !line_out);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready != busy);

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(line_raw)));

endmodule

bind uart_frame_tx uft_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_16x),
  .accept   (accept),
  .busy     (tx_busy),
  .ready    (tx_ready),
  .brk      (lc_break),
  .line_out (tx_line),
  .line_raw (line_raw)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

  localparam int TPB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic [1:0] lc_wlen = 2'b00;
  logic       lc_stop = 1'b0, lc_par_en = 1'b0, lc_even = 1'b0;
  logic       lc_stick = 1'b0, lc_break = 1'b0;
  logic       tx_ready, tx_line, tx_busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int per    = 1;
  int tcnt   = 0;
  int q[$];   // one entry per strobe: level + 2*requirement

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .lc_wlen(lc_wlen), .lc_stop(lc_stop), .lc_par_en(lc_par_en),
    .lc_even(lc_even), .lc_stick(lc_stick), .lc_break(lc_break),
    .tx_line(tx_line), .tx_busy(tx_busy)
  );

  always #4 clk = ~clk;   // 125 MHz

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d at cycle %0d",
               req, what, act, exp, cyc);
    end
  endtask

  // strobe generator, driven away from the active edge
  always @(negedge clk) begin
    tick_16x <= (tcnt == per - 1);
    tcnt     <= (tcnt >= per - 1) ? 0 : tcnt + 1;
  end

  task automatic push_bits(input int lvl, input int req, input int n);
    for (int i = 0; i < n; i++) q.push_back(lvl + 2 * req);
  endtask

  // build the expected strobe-by-strobe line for one accepted byte
  task automatic fill_frame();
    int nb, ones, p;
    nb = 5 + lc_wlen;
    ones = 0;
    push_bits(0, 2, TPB);                              // R2 start bit
    for (int i = 0; i < nb; i++) begin
      push_bits(tx_data[i], 2, TPB);                   // R2 data LSB first
      ones += tx_data[i];
    end
    if (lc_par_en) begin                               // R3 none when disabled
      if (lc_stick)     push_bits(lc_even ? 0 : 1, 6, TPB);          // R6
      else if (lc_even) push_bits(ones % 2, 4, TPB);                 // R4
      else begin p = 1 - (ones % 2); push_bits(p, 5, TPB); end       // R5
    end
    push_bits(1, 7, !lc_stop ? TPB : (lc_wlen == 2'b00 ? 24 : 32));  // R7
  endtask

  // reference model and per-cycle comparison
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
    if (!rst_n) q.delete();
    else if (q.size() > 0) begin
      if (tick_16x) void'(q.pop_front());
    end else if (tx_valid) fill_frame();   // R9 controls captured here
    #2;
    if (rst_n) begin : cmp
      int lvl, req, exp_line;
      lvl = (q.size() > 0) ? (q[0] & 1) : 1;
      req = (q.size() > 0) ? (q[0] >> 1) : 1;
      exp_line = lc_break ? 0 : lvl;
      if (lc_break) req = 8;                 // R8 forced low
      check(tx_line == exp_line, req, "line", tx_line, exp_line);
      // R10 handshake and busy window
      check(tx_ready == (q.size() == 0), 10, "ready", tx_ready, q.size() == 0);
      check(tx_busy  == (q.size() != 0), 10, "busy", tx_busy, q.size() != 0);
    end
  end

  task automatic set_lc(input logic [1:0] wl, input bit sb, input bit pe,
                        input bit ev, input bit st);
    lc_wlen = wl; lc_stop = sb; lc_par_en = pe; lc_even = ev; lc_stick = st;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = ~d;   // later data changes must not matter
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_line == 1'b1, 1, "reset line", tx_line, 1);
    check(tx_ready == 1'b1, 1, "reset ready", tx_ready, 1);
    check(tx_busy == 1'b0, 1, "reset busy", tx_busy, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R4 R5 R6 R7: every word length, stop mode and parity mode
    for (int wl = 0; wl < 4; wl++)
      for (int sb = 0; sb < 2; sb++)
        for (int pm = 0; pm < 6; pm++) begin
          case (pm)
            0: set_lc(wl[1:0], sb[0], 1'b0, 1'b0, 1'b0);   // R3
            1: set_lc(wl[1:0], sb[0], 1'b0, 1'b1, 1'b1);   // R3 even ignored
            2: set_lc(wl[1:0], sb[0], 1'b1, 1'b1, 1'b0);   // R4
            3: set_lc(wl[1:0], sb[0], 1'b1, 1'b0, 1'b0);   // R5
            4: set_lc(wl[1:0], sb[0], 1'b1, 1'b1, 1'b1);   // R6 stick 0
            default: set_lc(wl[1:0], sb[0], 1'b1, 1'b0, 1'b1); // R6 stick 1
          endcase
          send(8'h5A ^ 8'(wl * 37 + sb * 11 + pm * 71));
          wait_idle();
        end

    // R10 slower strobe: line must only move on strobe edges
    per = 3;
    set_lc(2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'hC3);
    wait_idle();
    per = 1;

    // R9 controls changed mid-frame
    set_lc(2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    send(8'h1D);
    repeat (30) @(negedge clk);
    set_lc(2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (60) @(negedge clk);
    set_lc(2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_idle();

    // R8 break during a frame and while idle
    set_lc(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    send(8'hA5);
    repeat (40) @(negedge clk);
    lc_break = 1'b1;
    repeat (70) @(negedge clk);
    lc_break = 1'b0;
    wait_idle();
    lc_break = 1'b1;
    repeat (10) @(negedge clk);
    lc_break = 1'b0;

    // R10 valid held high: back-to-back frames
    set_lc(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    tx_data = 8'h3C; tx_valid = 1'b1;
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_idle();

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule